// File: doc/BRIEF.md
# Microwire EEPROM Burst Controller

This block is a host-side master for a three-wire-plus-select serial EEPROM that holds 16-bit words. A client hands it one request (first word address, a length, and a direction) and the block runs the whole burst on its own. It builds every command frame, generates the serial clock from the system clock, and moves the data words through two valid/ready streams. Read words come out on one stream and write words are taken from the other. The word address is `ADDR_W` bits wide, and the parameter allows 6 or 8.

Each serial bit takes one cell: a low half followed by a high half. Outputs change only while the serial clock is low, and input data is sampled at the end of the high half. Every command begins with a select cell, where chip select is high and data is 0, and ends with a cell where chip select is low, which returns the device to its idle state. A write burst is bracketed by an enable command before the first word and a disable command after the last. After each written word the block polls the device's ready indication. It stops polling once the device reports ready, or once a bounded number of poll cells has gone by.

Top module: `mw_eeprom_burst`

## Requirements
- R1: After reset, `mw_cs`, `mw_sclk`, `mw_do`, `busy`, `done`, `err`, `rd_valid` and `wr_ready` are all low.
- R2: A read word is sent as a select cell, then the opcode bits 1,1,0, then the `ADDR_W` address bits MSB first, all with `mw_cs` high.
- R3: A read word samples `mw_di` in 17 cells and keeps the last 16 samples, so the leading dummy zero is dropped. The word is presented on `rd_data` with `rd_valid` held, and `rd_data` stays stable, until `rd_ready` is seen.
- R4: A request with length field L moves L+1 words, at addresses start, start+1, ..., start+L (modulo 2^`ADDR_W`), and performs one complete command per word.
- R5: A write burst first sends the enable command and finishes with the disable command. The enable command is 1,0,0,1,1 and the disable command is 1,0,0,0,0, each padded with zeros to `ADDR_W`+3 bits.
- R6: A write word is sent once `wr_valid` meets `wr_ready`, as a select cell, the bits 1,0,1, the address MSB first, and the 16 data bits MSB first. `wr_ready` stays high until a word is taken.
- R7: Every command is followed by one cell with `mw_cs` low. After a write's data bits, `mw_cs` is low for one cell and then high for poll cells until `mw_di` samples high. While the block is not busy, `mw_cs` and `mw_sclk` are low.
- R8: `mw_do` and `mw_cs` change only in cycles where `mw_sclk` is low.
- R9: Each high half of `mw_sclk` lasts exactly `DIV` system clocks, and each low half lasts at least `DIV` system clocks.
- R10: If `POLL_MAX` poll cells pass without `mw_di` high, the block drops select, sends the disable command, raises `err` together with `done`, and requests no further write words.
- R11: `busy` rises on the clock after an accepted request and falls in the same cycle as the one-cycle `done` pulse. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | First word address |
| req_len | input | LEN_W | Number of words minus one |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when the burst ends |
| err | output | 1 | With `done`: the ready poll timed out |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Client takes the read word |
| rd_data | output | 16 | Read word |
| wr_valid | input | 1 | Client offers a write word |
| wr_ready | output | 1 | Block is waiting for a write word |
| wr_data | input | 16 | Write word |
| mw_cs | output | 1 | Device chip select |
| mw_sclk | output | 1 | Device serial clock |
| mw_do | output | 1 | Serial data to the device |
| mw_di | input | 1 | Serial data from the device |

## Verification
A read word costs 1+3+`ADDR_W`+17+1 serial cells before `rd_valid` rises. Each cell takes 2·`DIV`+1 system clocks, so with the bench settings the first word is due about 140 clocks after the request. Write words and the poll loop depend on how long the device model stays busy. For that reason the checks do not count cycles blindly. They sample on the falling system clock edge and wait for the handshake or the `done` pulse that each result is tied to. `busy` is checked exactly one clock after the request, and `rd_data` is compared on every cycle of a deliberately stalled `rd_ready`. A bus model built into the bench decodes every frame on the serial pins. It reports opcodes, addresses and command order, and it watches the half-period lengths and which edge each pin changes on.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SHIFT,
    ST_RCAP,
    ST_RST,
    ST_RVAL,
    ST_WWAIT,
    ST_GAP,
    ST_POLL
  } seq_state_e;

  typedef enum logic [1:0] {
    CM_EWEN,
    CM_READ,
    CM_WRITE,
    CM_EWDS
  } cmd_e;
endpackage

// File: rtl/mwb_cell.sv
// One serial bit cell: low half, high half, sample at the end of the high half.
module mwb_cell #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_cs,
  input  logic go_do,
  input  logic din,
  output logic sclk,
  output logic cs,
  output logic dout,
  output logic done,
  output logic smp
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic          active_q, active_d;
  logic          high_q, high_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cs_q, cs_d;
  logic          do_q, do_d;
  logic          done_q, done_d;
  logic          smp_q, smp_d;

  always_comb begin
    active_d = active_q;
    high_d   = high_q;
    cnt_d    = cnt_q;
    cs_d     = cs_q;
    do_d     = do_q;
    done_d   = 1'b0;
    smp_d    = smp_q;
    if (go) begin
      active_d = 1'b1;
      high_d   = 1'b0;
      cnt_d    = '0;
      cs_d     = go_cs;
      do_d     = go_do;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        if (!high_q) begin
          high_d = 1'b1;
        end else begin
          high_d   = 1'b0;
          active_d = 1'b0;
          done_d   = 1'b1;
          smp_d    = din;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
      cnt_q    <= '0;
      cs_q     <= 1'b0;
      do_q     <= 1'b0;
      done_q   <= 1'b0;
      smp_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      high_q   <= high_d;
      cnt_q    <= cnt_d;
      cs_q     <= cs_d;
      do_q     <= do_d;
      done_q   <= done_d;
      smp_q    <= smp_d;
    end
  end

  assign sclk = high_q;
  assign cs   = cs_q;
  assign dout = do_q;
  assign done = done_q;
  assign smp  = smp_q;
endmodule

// File: rtl/mwb_frame.sv
// Builds the left-aligned serial frame and its bit count for one command.
module mwb_frame
  import mwb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LB     = 5
) (
  input  cmd_e                            cmd,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [WORD_W-1:0]               data,
  output logic [OPC_W+ADDR_W+WORD_W-1:0]  vec,
  output logic [LB-1:0]                   len
);
  localparam int PAD = ADDR_W - 2;
  localparam logic [LB-1:0] SHORT_LEN = LB'(OPC_W + ADDR_W);
  localparam logic [LB-1:0] LONG_LEN  = LB'(OPC_W + ADDR_W + WORD_W);

  always_comb begin
    unique case (cmd)
      CM_READ: begin
        vec = {3'b110, addr, {WORD_W{1'b0}}};
        len = SHORT_LEN;
      end
      CM_WRITE: begin
        vec = {3'b101, addr, data};
        len = LONG_LEN;
      end
      CM_EWEN: begin
        vec = {3'b100, 2'b11, {PAD{1'b0}}, {WORD_W{1'b0}}};
        len = SHORT_LEN;
      end
      default: begin
        vec = {3'b100, 2'b00, {PAD{1'b0}}, {WORD_W{1'b0}}};
        len = SHORT_LEN;
      end
    endcase
  end
endmodule

// File: rtl/mwb_seq.sv
// Burst sequencer: commands, word loop, ready poll, client handshakes.
module mwb_seq
  import mwb_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LEN_W    = 4,
  parameter int POLL_MAX = 64,
  parameter int FW       = 25,
  parameter int LB       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cell_done,
  input  logic              cell_smp,
  output logic              cell_go,
  output logic              cell_cs,
  output logic              cell_do,
  output cmd_e              fr_cmd,
  output logic [ADDR_W-1:0] fr_addr,
  output logic [WORD_W-1:0] fr_data,
  input  logic [FW-1:0]     fr_vec,
  input  logic [LB-1:0]     fr_len
);
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
  localparam logic [LB-1:0] RD_CELLS  = LB'(WORD_W + 1);

  seq_state_e        st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic [LB-1:0]     bits_q, bits_d;
  logic [PW-1:0]     poll_q, poll_d;
  logic              tout_q, tout_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    left_d  = left_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    sh_d    = sh_q;
    bits_d  = bits_q;
    poll_d  = poll_q;
    tout_d  = tout_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    cell_go = 1'b0;
    cell_cs = 1'b0;
    cell_do = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d  = req_addr;
          left_d  = req_len;
          tout_d  = 1'b0;
          busy_d  = 1'b1;
          cmd_d   = req_write ? CM_EWEN : CM_READ;
          cell_go = 1'b1;
          cell_cs = 1'b1;
          st_d    = ST_SEL;
        end
      end
      ST_SEL: begin
        if (cell_done) begin
          cell_go = 1'b1;
          cell_cs = 1'b1;
          cell_do = fr_vec[FW-1];
          sh_d    = fr_vec << 1;
          bits_d  = fr_len - LB'(1);
          st_d    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (cell_done) begin
          cell_go = 1'b1;
          if (bits_q != '0) begin
            cell_cs = 1'b1;
            cell_do = sh_q[FW-1];
            sh_d    = sh_q << 1;
            bits_d  = bits_q - LB'(1);
          end else if (cmd_q == CM_READ) begin
            cell_cs = 1'b1;
            bits_d  = RD_CELLS;
            st_d    = ST_RCAP;
          end else if (cmd_q == CM_WRITE) begin
            st_d = ST_GAP;
          end else begin
            st_d = ST_RST;
          end
        end
      end
      ST_RCAP: begin
        if (cell_done) begin
          rdat_d  = {rdat_q[WORD_W-2:0], cell_smp};
          cell_go = 1'b1;
          if (bits_q == LB'(1)) begin
            st_d = ST_RST;
          end else begin
            cell_cs = 1'b1;
            bits_d  = bits_q - LB'(1);
          end
        end
      end
      ST_RST: begin
        if (cell_done) begin
          unique case (cmd_q)
            CM_READ: st_d = ST_RVAL;
            CM_EWEN: st_d = ST_WWAIT;
            CM_WRITE: begin
              if (tout_q || (left_q == '0)) begin
                cmd_d   = CM_EWDS;
                cell_go = 1'b1;
                cell_cs = 1'b1;
                st_d    = ST_SEL;
              end else begin
                addr_d = addr_q + ADDR_W'(1);
                left_d = left_q - LEN_W'(1);
                st_d   = ST_WWAIT;
              end
            end
            default: begin
              busy_d = 1'b0;
              done_d = 1'b1;
              err_d  = tout_q;
              st_d   = ST_IDLE;
            end
          endcase
        end
      end
      ST_RVAL: begin
        if (rd_ready) begin
          if (left_q == '0) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            addr_d  = addr_q + ADDR_W'(1);
            left_d  = left_q - LEN_W'(1);
            cell_go = 1'b1;
            cell_cs = 1'b1;
            st_d    = ST_SEL;
          end
        end
      end
      ST_WWAIT: begin
        if (wr_valid) begin
          wdat_d  = wr_data;
          cmd_d   = CM_WRITE;
          cell_go = 1'b1;
          cell_cs = 1'b1;
          st_d    = ST_SEL;
        end
      end
      ST_GAP: begin
        if (cell_done) begin
          poll_d  = '0;
          cell_go = 1'b1;
          cell_cs = 1'b1;
          st_d    = ST_POLL;
        end
      end
      ST_POLL: begin
        if (cell_done) begin
          cell_go = 1'b1;
          if (cell_smp) begin
            st_d = ST_RST;
          end else if (poll_q == POLL_LAST) begin
            tout_d = 1'b1;
            st_d   = ST_RST;
          end else begin
            cell_cs = 1'b1;
            poll_d  = poll_q + PW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CM_READ;
      addr_q <= '0;
      left_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      sh_q   <= '0;
      bits_q <= '0;
      poll_q <= '0;
      tout_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      left_q <= left_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
      sh_q   <= sh_d;
      bits_q <= bits_d;
      poll_q <= poll_d;
      tout_q <= tout_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = (st_q == ST_RVAL);
  assign wr_ready = (st_q == ST_WWAIT);
  assign rd_data  = rdat_q;
  assign fr_cmd   = cmd_q;
  assign fr_addr  = addr_q;
  assign fr_data  = wdat_q;
endmodule

// File: rtl/mw_eeprom_burst.sv
module mw_eeprom_burst
  import mwb_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LEN_W    = 4,
  parameter int DIV      = 2,
  parameter int POLL_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [15:0]       rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [15:0]       wr_data,
  output logic              mw_cs,
  output logic              mw_sclk,
  output logic              mw_do,
  input  logic              mw_di
);
  localparam int FW = OPC_W + ADDR_W + WORD_W;
  localparam int LB = $clog2(FW + 1);

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic              cell_go, cell_cs, cell_do, cell_done, cell_smp;
  cmd_e              fr_cmd;
  logic [ADDR_W-1:0] fr_addr;
  logic [WORD_W-1:0] fr_data;
  logic [FW-1:0]     fr_vec;
  logic [LB-1:0]     fr_len;

  mwb_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .POLL_MAX(POLL_MAX), .FW(FW), .LB(LB)
  ) u_seq (
    .clk(clk), .rst_n(srst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cell_done(cell_done), .cell_smp(cell_smp),
    .cell_go(cell_go), .cell_cs(cell_cs), .cell_do(cell_do),
    .fr_cmd(fr_cmd), .fr_addr(fr_addr), .fr_data(fr_data),
    .fr_vec(fr_vec), .fr_len(fr_len)
  );

  mwb_frame #(.ADDR_W(ADDR_W), .LB(LB)) u_frame (
    .cmd(fr_cmd), .addr(fr_addr), .data(fr_data),
    .vec(fr_vec), .len(fr_len)
  );

  mwb_cell #(.DIV(DIV)) u_cell (
    .clk(clk), .rst_n(srst_n),
    .go(cell_go), .go_cs(cell_cs), .go_do(cell_do),
    .din(mw_di),
    .sclk(mw_sclk), .cs(mw_cs), .dout(mw_do),
    .done(cell_done), .smp(cell_smp)
  );
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_data,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        mw_cs,
  input logic        mw_sclk,
  input logic        mw_do
);
  localparam int HW = $clog2(DIV + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (mw_sclk) hi_cnt <= hi_cnt + HW'(1);
    else              hi_cnt <= '0;
  end

  assert_do_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_do != $past(mw_do)) |-> !mw_sclk);

  assert_cs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_cs != $past(mw_cs)) |-> !mw_sclk);

  assert_high_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_sclk) |-> (hi_cnt == HW'(DIV)));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_wr_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> wr_ready);

  assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mw_cs && !mw_sclk));

  assert_err_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_done_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind mw_eeprom_burst mwb_checker #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_do(mw_do)
);

// File: tb/mw_eeprom_burst_bench.sv
`timescale 1ns/1ps
module mw_eeprom_burst_bench;
  localparam int ADDR_W = 6;
  localparam int LEN_W  = 4;
  localparam int DIV    = 2;
  localparam int PMAX   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic busy, done, err, rd_valid, wr_ready;
  logic rd_ready = 1'b0, wr_valid = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] wr_data = '0;
  logic mw_cs, mw_sclk, mw_do;
  logic dev_do = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DIV(DIV), .POLL_MAX(PMAX)) u_mw_eeprom_burst (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_do(mw_do), .mw_di(dev_do)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model on the serial pins ----------------
  logic [15:0] mem [64];
  int phase = 0, nb = 0, ridx = 0;
  logic [1:0] op;
  logic [5:0] ad;
  logic [15:0] wd;
  bit we_en = 0, polling = 0;
  int busy_left = 0, busy_len = 3;
  int n_read = 0, n_write = 0, n_ewen = 0, n_ewds = 0, n_bad = 0, n_csfall = 0;
  int rd_log [16];
  int wr_log [16];
  int ev_log [16];   // 1 enable, 2 write, 3 disable
  int n_ev = 0;

  always @(posedge mw_sclk) begin
    if (mw_cs) begin
      if (polling) begin
        if (busy_left > 0) begin busy_left--; dev_do = 1'b0; end
        else dev_do = 1'b1;
      end else begin
        case (phase)
          0: if (mw_do) begin phase = 1; nb = 0; end
          1: begin
            op = {op[0], mw_do}; nb++;
            if (nb == 2) begin phase = 2; nb = 0; ad = '0; end
          end
          2: begin
            ad = {ad[4:0], mw_do}; nb++;
            if (nb == ADDR_W) begin
              nb = 0;
              if (op == 2'b10) begin
                rd_log[n_read % 16] = int'(ad); n_read++; phase = 4; ridx = 0;
              end else if (op == 2'b01) begin
                phase = 3; wd = '0;
              end else if (op == 2'b00 && ad[5:4] == 2'b11) begin
                we_en = 1; n_ewen++; ev_log[n_ev % 16] = 1; n_ev++; phase = 5;
              end else if (op == 2'b00 && ad[5:4] == 2'b00) begin
                we_en = 0; n_ewds++; ev_log[n_ev % 16] = 3; n_ev++; phase = 5;
              end else begin
                n_bad++; phase = 5;
              end
            end
          end
          3: begin
            wd = {wd[14:0], mw_do}; nb++;
            if (nb == 16) phase = 6;
          end
          4: begin
            if (ridx == 0) dev_do = 1'b0;
            else if (ridx <= 16) dev_do = mem[ad][16-ridx];
            ridx++;
          end
          5: if (mw_do) n_bad++;
          default: ;
        endcase
      end
    end
  end

  always @(negedge mw_cs) begin
    n_csfall++;
    if (polling) begin
      polling = 0; dev_do = 1'b0;
    end else begin
      if (phase == 6) begin
        if (we_en) begin
          mem[ad] = wd; wr_log[n_write % 16] = int'(ad); n_write++;
          ev_log[n_ev % 16] = 2; n_ev++;
        end else n_bad++;
        polling = 1; busy_left = busy_len; dev_do = 1'b0;
      end else if (phase != 5 && phase != 4 && phase != 0) begin
        n_bad++;
      end
      dev_do = polling ? 1'b0 : dev_do;
    end
    phase = 0;
  end

  // ---------------- pin timing monitor (R8, R9) ----------------
  int hi_run = 0, lo_run = 0, n_hi_bad = 0, n_lo_bad = 0, n_edge_bad = 0;
  logic p_sclk = 1'b0, p_do = 1'b0, p_cs = 1'b0;
  int n_done = 0;
  bit last_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mw_do !== p_do || mw_cs !== p_cs) && mw_sclk) n_edge_bad++;
      if (mw_sclk) begin
        if (!p_sclk && busy && lo_run < DIV) n_lo_bad++;
        hi_run++; lo_run = 0;
      end else begin
        if (p_sclk && hi_run != DIV) n_hi_bad++;
        lo_run++; hi_run = 0;
      end
      if (done) begin n_done++; last_err = err; end
    end
    p_sclk = mw_sclk; p_do = mw_do; p_cs = mw_cs;
  end

  // ---------------- helpers ----------------
  task automatic issue(input bit wr, input int a, input int l);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = ADDR_W'(a); req_len = LEN_W'(l);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'hA5C3 ^ (16'(i) * 16'h1357);
  endfunction

  task automatic read_burst(input int a, input int l, input string tag);
    int d0, r0, c0, got;
    d0 = n_done; r0 = n_read; c0 = n_csfall; got = 0;
    issue(1'b0, a, l);
    chk(busy === 1'b1, "R11", {tag, " busy after request"}, busy, 1);
    while (n_done == d0) begin
      @(negedge clk);
      rd_ready = 1'b0;
      if (rd_valid) begin
        chk(rd_data === mem[(a + got) % 64], "R3", {tag, " read word"},
            rd_data, mem[(a + got) % 64]);
        rd_ready = 1'b1; got++;
      end
    end
    rd_ready = 1'b0;
    chk(got == l + 1, "R4", {tag, " words delivered"}, got, l + 1);
    chk(n_read - r0 == l + 1, "R2", {tag, " read commands decoded"}, n_read - r0, l + 1);
    for (int i = 0; i <= l; i++)
      chk(rd_log[(r0 + i) % 16] == (a + i) % 64, "R4", {tag, " address order"},
          rd_log[(r0 + i) % 16], (a + i) % 64);
    chk(n_csfall - c0 == l + 1, "R7", {tag, " select drops"}, n_csfall - c0, l + 1);
    chk(!last_err && !busy, "R11", {tag, " clean end"}, {last_err, busy}, 0);
  endtask

  task automatic write_burst(input int a, input int l, input int seed,
                             input bit expect_tout, input string tag);
    int d0, w0, e0, s0, v0, taken;
    d0 = n_done; w0 = n_write; e0 = n_ewen; s0 = n_ewds; v0 = n_ev; taken = 0;
    issue(1'b1, a, l);
    while (n_done == d0) begin
      @(negedge clk);
      wr_valid = 1'b0;
      if (wr_ready) begin
        wr_valid = 1'b1; wr_data = pat(seed + taken); taken++;
      end
    end
    wr_valid = 1'b0;
    chk(n_ewen - e0 == 1, "R5", {tag, " one enable"}, n_ewen - e0, 1);
    chk(n_ewds - s0 == 1, "R5", {tag, " one disable"}, n_ewds - s0, 1);
    chk(ev_log[v0 % 16] == 1, "R5", {tag, " enable first"}, ev_log[v0 % 16], 1);
    chk(ev_log[(n_ev - 1) % 16] == 3, "R5", {tag, " disable last"}, ev_log[(n_ev - 1) % 16], 3);
    chk(we_en == 0, "R5", {tag, " left protected"}, we_en, 0);
    if (expect_tout) begin
      chk(last_err == 1'b1, "R10", {tag, " err with done"}, last_err, 1);
      chk(taken == 1, "R10", {tag, " no further words"}, taken, 1);
    end else begin
      chk(last_err == 1'b0, "R6", {tag, " no error"}, last_err, 0);
      chk(taken == l + 1 && n_write - w0 == l + 1, "R6", {tag, " words written"},
          n_write - w0, l + 1);
      for (int i = 0; i <= l; i++) begin
        chk(mem[(a + i) % 64] === pat(seed + i), "R6", {tag, " stored data"},
            mem[(a + i) % 64], pat(seed + i));
        chk(wr_log[(w0 + i) % 16] == (a + i) % 64, "R4", {tag, " write address"},
            wr_log[(w0 + i) % 16], (a + i) % 64);
      end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({mw_cs, mw_sclk, mw_do, busy, done, err, rd_valid, wr_ready} == 8'h00,
        "R1", "pins and status in reset", {mw_cs, mw_sclk, mw_do, busy, done, err, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({mw_cs, mw_sclk, mw_do, busy, done, rd_valid, wr_ready} == 7'h00,
        "R1", "idle after release", {mw_cs, mw_sclk, mw_do, busy, done, rd_valid, wr_ready}, 0);
  endtask

  task automatic t_read_stall();
    int d0, bad;
    logic [15:0] first;
    d0 = n_done; bad = 0;
    issue(1'b0, 20, 0);
    while (!rd_valid) @(negedge clk);
    first = rd_data;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rd_valid || rd_data !== first) bad++;
    end
    chk(bad == 0, "R3", "word held under stall", bad, 0);
    chk(first === mem[20], "R3", "stalled word value", first, mem[20]);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    while (n_done == d0) @(negedge clk);
    chk(!busy, "R11", "done after stall", busy, 0);
  endtask

  task automatic t_busy_ignore();
    int d0, e0, r0, got;
    d0 = n_done; e0 = n_ewen; r0 = n_read; got = 0;
    issue(1'b0, 3, 1);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd40; req_len = '0;
    @(negedge clk);
    req_valid = 1'b0;
    while (n_done == d0) begin
      @(negedge clk);
      rd_ready = 1'b0;
      if (rd_valid) begin rd_ready = 1'b1; got++; end
    end
    rd_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_ewen == e0 && !busy, "R11", "request during busy ignored", n_ewen - e0, 0);
    chk(n_read - r0 == 2 && got == 2, "R11", "only first burst ran", n_read - r0, 2);
  endtask

  task automatic t_timeout();
    busy_len = 1000;
    write_burst(30, 2, 77, 1'b1, "timeout");
    busy_len = 3;
  endtask

  task automatic t_pins();
    chk(n_edge_bad == 0, "R8", "pin change while clock high", n_edge_bad, 0);
    chk(n_hi_bad == 0, "R9", "high half length", n_hi_bad, 0);
    chk(n_lo_bad == 0, "R9", "low half length", n_lo_bad, 0);
    chk(n_bad == 0, "R2", "malformed frames seen by device", n_bad, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = pat(i * 3 + 1);
    t_reset();
    read_burst(5, 2, "read3");
    read_burst(62, 1, "readtop");
    read_burst(63, 1, "readwrap");
    t_read_stall();
    write_burst(10, 1, 200, 1'b0, "write2");
    busy_len = 0;
    write_burst(63, 0, 300, 1'b0, "write1");
    busy_len = 3;
    read_burst(10, 1, "readback");
    t_busy_ignore();
    t_timeout();
    t_pins();
    summary();
    $finish;
  end
endmodule